// File: doc/BRIEF.md
# Fault-Injecting Bit Memory Array

This block is a small synchronous RAM, one bit wide, into which a single defect of a chosen kind can be placed. It exists to give a memory test controller (for example a march-sequence engine) a target whose failures are known in advance. A good controller must report the defect that was switched on, and must report nothing when none is.

Accesses use one port: an access strobe, a write enable, an address and a data bit. Read data appears one cycle after the read. A second port holds the fault setup: the fault kind, a victim address, an aggressor address, a polarity bit and a forced-value bit. The setup is captured only in a cycle with no access.

Top module: `fault_mem_array`

## Requirements
- R1: With fault kind code 0 (none), a read issued in cycle n returns, in cycle n+1, the last value written to that address.
- R2: With kind code 1 (stuck-at), every read of the victim returns the forced-value bit, whatever was written to the victim. Other addresses behave as in R1.
- R3: With kind code 2 (transition), polarity 1 blocks the victim's 0-to-1 change and polarity 0 blocks its 1-to-0 change. A blocked write leaves the old value. The change in the other direction works normally.
- R4: With kind code 3 (inversion coupling), a write that changes the aggressor's stored value flips the victim's stored value in the same cycle. This happens only for a change in the configured direction: polarity 1 means 0-to-1 and polarity 0 means 1-to-0. A write that leaves the aggressor unchanged has no effect on the victim.
- R5: With kind code 4 (idempotent coupling), a change of the aggressor in the configured direction (same encoding as R4) sets the victim to the forced-value bit. Other aggressor writes leave the victim alone.
- R6: With kind code 5 (state coupling), a read of the victim returns the forced-value bit while the aggressor holds the state given by the polarity bit. At all other times the read returns the victim's stored value.
- R7: With kind code 6 (decode alias), a write to the aggressor address also writes the victim cell. A read of the aggressor address returns the AND of both cells when polarity is 0, and their OR when polarity is 1.
- R8: A setup load (cfg_load high) in a cycle where the access strobe is also high is ignored. The previous setup stays in force.
- R9: Reset clears every cell and rd_data to 0 and selects fault kind none.
- R10: rd_data keeps its value in every cycle that follows a cycle with no read.
- R11: The coupling kinds (codes 3, 4 and 5) have no effect when the victim address equals the aggressor address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 1 | Write data bit |
| rd_data | output | 1 | Read result, one cycle after the read |
| cfg_load | input | 1 | Capture the setup (only while idle) |
| cfg_kind | input | 3 | Fault kind code 0..6 |
| cfg_victim | input | ADDR_W | Victim address |
| cfg_aggr | input | ADDR_W | Aggressor / faulty address |
| cfg_pol | input | 1 | Direction, aggressor state or alias combine |
| cfg_val | input | 1 | Forced value |

## Verification
The bench builds the array with ADDR_W = 3, which gives eight cells. At that size every victim address can be swept for stuck-at and transition faults, and every ordered victim/aggressor pair for the coupling and alias kinds. This exposes decoding mistakes that only show up for particular address pairs. Both polarities and both forced values are run, so each trigger direction and each read-override combine is covered.

// File: rtl/fim_pkg.sv
// Shared types for the fault-injecting memory array.
// Assumes: the kind codes below are part of the external setup interface.
package fim_pkg;
    typedef enum logic [2:0] {
        FK_NONE  = 3'd0,
        FK_STUCK = 3'd1,
        FK_TRANS = 3'd2,
        FK_INV   = 3'd3,
        FK_IDEM  = 3'd4,
        FK_STATE = 3'd5,
        FK_ALIAS = 3'd6
    } fault_kind_t;
endpackage

// File: rtl/fim_cfg_reg.sv
// Holds the active fault setup.
// Assumes: a load is accepted only in a cycle with no access in flight.
module fim_cfg_reg
    import fim_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              busy,
    input  logic [2:0]        kind_in,
    input  logic [ADDR_W-1:0] vic_in,
    input  logic [ADDR_W-1:0] agg_in,
    input  logic              pol_in,
    input  logic              val_in,
    output fault_kind_t       kind_q,
    output logic [ADDR_W-1:0] vic_q,
    output logic [ADDR_W-1:0] agg_q,
    output logic              pol_q,
    output logic              val_q
);
    logic take;
    assign take = load && !busy;

    // Decode the raw kind code; codes outside 0..6 fall back to none.
    fault_kind_t kind_dec;
    always_comb begin
        case (kind_in)
            3'd1:    kind_dec = FK_STUCK;
            3'd2:    kind_dec = FK_TRANS;
            3'd3:    kind_dec = FK_INV;
            3'd4:    kind_dec = FK_IDEM;
            3'd5:    kind_dec = FK_STATE;
            3'd6:    kind_dec = FK_ALIAS;
            default: kind_dec = FK_NONE;
        endcase
    end

    // Capture the setup when the array is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= FK_NONE;
            vic_q  <= '0;
            agg_q  <= '0;
            pol_q  <= 1'b0;
            val_q  <= 1'b0;
        end else if (take) begin
            kind_q <= kind_dec;
            vic_q  <= vic_in;
            agg_q  <= agg_in;
            pol_q  <= pol_in;
            val_q  <= val_in;
        end
    end
endmodule

// File: rtl/fim_write_engine.sv
// Combinational next-state of the cell array for one write.
// Assumes: called with the current cells; coupling uses the aggressor's
// old stored value and the new write bit of the same cycle.
module fim_write_engine
    import fim_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [DEPTH-1:0]  cells,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wdata,
    input  fault_kind_t       kind,
    input  logic [ADDR_W-1:0] vic,
    input  logic [ADDR_W-1:0] agg,
    input  logic              pol,
    input  logic              val,
    output logic [DEPTH-1:0]  cells_nxt
);
    logic old_bit;
    logic agg_old;
    logic blocked;
    logic edge_ok;
    logic coupled;

    // Classify the write: blocked transition and aggressor trigger.
    always_comb begin
        old_bit = cells[addr];
        agg_old = cells[agg];
        blocked = 1'b0;
        if (kind == FK_TRANS && addr == vic)
            blocked = pol ? (!old_bit && wdata) : (old_bit && !wdata);
        edge_ok = pol ? (!agg_old && wdata) : (agg_old && !wdata);
        coupled = (kind == FK_INV || kind == FK_IDEM) && (vic != agg)
                  && (addr == agg) && edge_ok;
    end

    // Build the updated array.
    always_comb begin
        cells_nxt = cells;
        if (wr_en) begin
            if (!blocked)
                cells_nxt[addr] = wdata;
            if (kind == FK_ALIAS && addr == agg)
                cells_nxt[vic] = wdata;
            if (coupled)
                cells_nxt[vic] = (kind == FK_INV) ? ~cells[vic] : val;
        end
    end
endmodule

// File: rtl/fim_read_port.sv
// Registered read path with read-time fault overrides.
// Assumes: rd_data changes only in the cycle after a read.
module fim_read_port
    import fim_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DEPTH-1:0]  cells,
    input  fault_kind_t       kind,
    input  logic [ADDR_W-1:0] vic,
    input  logic [ADDR_W-1:0] agg,
    input  logic              pol,
    input  logic              val,
    output logic              rd_data
);
    logic eff;

    // Pick the value the faulty array would present.
    always_comb begin
        eff = cells[addr];
        case (kind)
            FK_STUCK: if (addr == vic) eff = val;
            FK_STATE: if (addr == vic && vic != agg && cells[agg] == pol) eff = val;
            FK_ALIAS: if (addr == agg)
                          eff = pol ? (cells[agg] | cells[vic])
                                    : (cells[agg] & cells[vic]);
            default:  eff = cells[addr];
        endcase
    end

    // Register the read result; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= 1'b0;
        else if (rd_en)
            rd_data <= eff;
    end
endmodule

// File: rtl/fault_mem_array.sv
// Bit-wide single-port RAM with one injectable defect.
// Assumes: one access per cycle; setup loaded only while idle.
module fault_mem_array
    import fim_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              rd_data,
    input  logic              cfg_load,
    input  logic [2:0]        cfg_kind,
    input  logic [ADDR_W-1:0] cfg_victim,
    input  logic [ADDR_W-1:0] cfg_aggr,
    input  logic              cfg_pol,
    input  logic              cfg_val
);
    fault_kind_t       cfg_kind_q;
    logic [ADDR_W-1:0] cfg_vic_q;
    logic [ADDR_W-1:0] cfg_agg_q;
    logic              cfg_pol_q;
    logic              cfg_val_q;
    logic [DEPTH-1:0]  cells;
    logic [DEPTH-1:0]  cells_nxt;

    fim_cfg_reg #(.ADDR_W(ADDR_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .busy(req_valid),
        .kind_in(cfg_kind), .vic_in(cfg_victim), .agg_in(cfg_aggr),
        .pol_in(cfg_pol), .val_in(cfg_val),
        .kind_q(cfg_kind_q), .vic_q(cfg_vic_q), .agg_q(cfg_agg_q),
        .pol_q(cfg_pol_q), .val_q(cfg_val_q)
    );

    fim_write_engine #(.ADDR_W(ADDR_W)) wr_i (
        .cells(cells), .wr_en(req_valid && req_we), .addr(req_addr),
        .wdata(req_wdata), .kind(cfg_kind_q), .vic(cfg_vic_q),
        .agg(cfg_agg_q), .pol(cfg_pol_q), .val(cfg_val_q),
        .cells_nxt(cells_nxt)
    );

    fim_read_port #(.ADDR_W(ADDR_W)) rd_i (
        .clk(clk), .rst_n(rst_n), .rd_en(req_valid && !req_we),
        .addr(req_addr), .cells(cells), .kind(cfg_kind_q),
        .vic(cfg_vic_q), .agg(cfg_agg_q), .pol(cfg_pol_q),
        .val(cfg_val_q), .rd_data(rd_data)
    );

    // Cell storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cells <= '0;
        else
            cells <= cells_nxt;
    end
endmodule

// File: rtl/fim_checker.sv
// Property checker for fault_mem_array, attached by bind.
module fim_checker
    import fim_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_wdata,
    input logic              rd_data,
    input logic              cfg_load,
    input fault_kind_t       cfg_kind_q,
    input logic [ADDR_W-1:0] cfg_vic_q,
    input logic [ADDR_W-1:0] cfg_agg_q,
    input logic              cfg_pol_q,
    input logic              cfg_val_q,
    input logic [DEPTH-1:0]  cells
);
    logic rd_now;
    logic wr_now;
    assign rd_now = req_valid && !req_we;
    assign wr_now = req_valid && req_we;

    AST_PLAIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && cfg_kind_q == FK_NONE) |=> rd_data == $past(cells[req_addr])); // R1
    AST_STUCK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && cfg_kind_q == FK_STUCK && req_addr == cfg_vic_q) |=> rd_data == $past(cfg_val_q)); // R2
    AST_TRANS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && cfg_kind_q == FK_TRANS && req_addr == cfg_vic_q &&
         (cfg_pol_q ? (!cells[req_addr] && req_wdata) : (cells[req_addr] && !req_wdata)))
        |=> cells[$past(req_addr)] == $past(cells[req_addr])); // R3
    AST_INV_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && cfg_kind_q == FK_INV && req_addr == cfg_agg_q && cfg_vic_q != cfg_agg_q &&
         (cfg_pol_q ? (!cells[cfg_agg_q] && req_wdata) : (cells[cfg_agg_q] && !req_wdata)))
        |=> cells[$past(cfg_vic_q)] != $past(cells[cfg_vic_q])); // R4
    AST_CFG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && req_valid) |=> ($stable(cfg_kind_q) && $stable(cfg_vic_q) &&
         $stable(cfg_agg_q) && $stable(cfg_pol_q) && $stable(cfg_val_q))); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_now |=> $stable(rd_data)); // R10
endmodule

bind fault_mem_array fim_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .cfg_load(cfg_load), .cfg_kind_q(cfg_kind_q), .cfg_vic_q(cfg_vic_q),
    .cfg_agg_q(cfg_agg_q), .cfg_pol_q(cfg_pol_q), .cfg_val_q(cfg_val_q),
    .cells(cells)
);

// File: tb/fault_mem_array_tb_top.sv
module fault_mem_array_tb_top;
    localparam int AW = 3;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic rd_data;
    logic cfg_load = 1'b0, cfg_pol = 1'b0, cfg_val = 1'b0;
    logic [2:0] cfg_kind = 3'd0;
    logic [AW-1:0] cfg_victim = '0, cfg_aggr = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fault_mem_array #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .cfg_load(cfg_load), .cfg_kind(cfg_kind), .cfg_victim(cfg_victim),
        .cfg_aggr(cfg_aggr), .cfg_pol(cfg_pol), .cfg_val(cfg_val)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic d);
        req_valid = 1; req_we = 1; req_addr = a[AW-1:0]; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_we = 0;
    endtask

    task automatic rd(input int a, output logic v);
        req_valid = 1; req_we = 0; req_addr = a[AW-1:0];
        @(negedge clk);
        v = rd_data;
        req_valid = 0;
    endtask

    task automatic setup(input int k, input int v, input int g, input logic p, input logic f);
        cfg_load = 1; cfg_kind = k[2:0]; cfg_victim = v[AW-1:0];
        cfg_aggr = g[AW-1:0]; cfg_pol = p; cfg_val = f;
        @(negedge clk);
        cfg_load = 0;
    endtask

    task automatic clear_all();
        setup(0, 0, 0, 0, 0);
        for (int a = 0; a < N; a++) wr(a, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 rd_data after reset", rd_data, 1'b0);
        for (int a = 0; a < N; a++) begin
            rd(a, v); chk("R9 cell cleared", v, 1'b0);
        end

        // R1 plain RAM under two patterns
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < N; a++) wr(a, logic'(((a >> p) ^ a) & 1));
            for (int a = 0; a < N; a++) begin
                rd(a, v); chk("R1 plain read", v, logic'(((a >> p) ^ a) & 1));
            end
        end

        // R10 hold: read a 1, then write a 0 elsewhere, rd_data stays
        wr(1, 1'b1); rd(1, v);
        wr(2, 1'b0);
        chk("R10 hold after write", rd_data, 1'b1);
        @(negedge clk);
        chk("R10 hold while idle", rd_data, 1'b1);

        // R2 stuck-at sweep
        for (int vi = 0; vi < N; vi++) begin
            for (int f = 0; f < 2; f++) begin
                clear_all();
                setup(1, vi, 0, 0, logic'(f));
                wr(vi, ~logic'(f));
                rd(vi, v); chk("R2 stuck victim", v, logic'(f));
                wr((vi + 1) % N, 1'b1);
                rd((vi + 1) % N, v); chk("R2 neighbour", v, 1'b1);
            end
        end

        // R3 transition sweep
        for (int vi = 0; vi < N; vi++) begin
            clear_all();
            setup(2, vi, 0, 1'b1, 0);
            wr(vi, 1'b1);
            rd(vi, v); chk("R3 rising blocked", v, 1'b0);
            clear_all();
            setup(2, vi, 0, 1'b0, 0);
            wr(vi, 1'b1);
            rd(vi, v); chk("R3 rising allowed", v, 1'b1);
            wr(vi, 1'b0);
            rd(vi, v); chk("R3 falling blocked", v, 1'b1);
        end

        // R4 inversion and R5 idempotent coupling, all pairs
        for (int vi = 0; vi < N; vi++) begin
            for (int g = 0; g < N; g++) begin
                if (g == vi) continue;
                clear_all();
                setup(3, vi, g, 1'b1, 0);
                wr(g, 1'b1); rd(vi, v); chk("R4 flip on rise", v, 1'b1);
                wr(g, 1'b1); rd(vi, v); chk("R4 no change no flip", v, 1'b1);
                wr(g, 1'b0); rd(vi, v); chk("R4 wrong direction", v, 1'b1);
                wr(g, 1'b1); rd(vi, v); chk("R4 flip back", v, 1'b0);
                clear_all();
                setup(4, vi, g, 1'b0, 1'b1);
                wr(g, 1'b1); rd(vi, v); chk("R5 wrong direction", v, 1'b0);
                wr(g, 1'b0); rd(vi, v); chk("R5 forced on fall", v, 1'b1);
                wr(vi, 1'b0);
                wr(g, 1'b0); rd(vi, v); chk("R5 no change no force", v, 1'b0);
            end
        end

        // R6 state coupling and R7 alias, all pairs
        for (int vi = 0; vi < N; vi++) begin
            for (int g = 0; g < N; g++) begin
                if (g == vi) continue;
                clear_all();
                setup(5, vi, g, 1'b1, 1'b0);
                wr(vi, 1'b1);
                rd(vi, v); chk("R6 aggressor not in state", v, 1'b1);
                wr(g, 1'b1);
                rd(vi, v); chk("R6 forced while held", v, 1'b0);
                wr(g, 1'b0);
                rd(vi, v); chk("R6 released", v, 1'b1);
                clear_all();
                setup(6, vi, g, 1'b0, 0);
                wr(g, 1'b1);
                rd(vi, v); chk("R7 write lands in alias", v, 1'b1);
                wr(vi, 1'b0);
                rd(g, v); chk("R7 AND combine", v, 1'b0);
                setup(6, vi, g, 1'b1, 0);
                rd(g, v); chk("R7 OR combine", v, 1'b1);
            end
        end

        // R11 coupling with victim == aggressor has no effect
        clear_all();
        setup(3, 4, 4, 1'b1, 0);
        wr(4, 1'b1); rd(4, v); chk("R11 inversion self", v, 1'b1);
        setup(5, 4, 4, 1'b1, 1'b0);
        rd(4, v); chk("R11 state self", v, 1'b1);

        // R8 setup load during an access is ignored
        clear_all();
        req_valid = 1; req_we = 0; req_addr = '0;
        cfg_load = 1; cfg_kind = 3'd1; cfg_victim = '0; cfg_val = 1'b1;
        @(negedge clk);
        req_valid = 0; cfg_load = 0;
        rd(0, v); chk("R8 busy load ignored", v, 1'b0);

        // R9 reset mid-run clears cells
        wr(5, 1'b1);
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        rd(5, v); chk("R9 reset clears cell", v, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule